// File: doc/BRIEF.md
# Speculative Store Buffer

This block keeps the address and data of stores that have executed but not yet committed, so the data cache is only written by stores that are known to be on the correct path. Each entry records a valid flag, a speculative flag, the store's program-order tag, its address and its data. An executed store takes a free entry and starts out speculative. A commit that names the store's tag clears its speculative flag. An abort that names the tag drops the entry. Committed entries then leave for the cache over a drain port with a ready handshake.

Loads look up the buffer by address and give their own tag. Among the entries that match, the buffer returns the data of the youngest store that is still older than the load. Buffer data always takes precedence over the cache. A miss tells the load path to use the cache value. Tags come from a circular sequence whose top bit flips on each wrap, so age is the sign of the tag difference. The set of tags in flight must span less than half the tag range.

Top module: `spec_store_buf`

## Requirements
- R1: A store accepted on the execute port (`st_valid` and `st_ready` both high at a clock edge) occupies an entry. While that entry is speculative, it is never offered on the drain port and the cache is not written.
- R2: A commit whose tag matches a speculative entry makes that entry eligible to drain. `drn_valid` is high with the store's address and data from the cycle after the commit edge.
- R3: An abort whose tag matches a speculative entry removes it. The entry is never drained, loads no longer see it, and its slot can be allocated again.
- R4: When a load hits in the buffer, `ld_hit` is 1 and `ld_data` is the buffered data, even when the cache holds a different value at that address.
- R5: When several live entries match the load address, `ld_data` comes from the youngest of those that are older than the load.
- R6: Entries whose tag equals the load's tag or is younger than it are not seen by that load.
- R7: Committed entries drain one per accepted handshake, oldest tag first. An offer is held until `drn_ready` is high, and the entry is freed at that edge.
- R8: When every entry is occupied, `st_ready` is 0 and a store presented then has no effect.
- R9: A load with no visible matching entry reports `ld_hit` = 0, so the cache value is used.
- R10: Age comparison is correct across the tag wrap. A tag is older than another when (other − tag), taken modulo 2^TAG_W, has its top bit clear and is non-zero. This applies to both the load lookup and the drain order.
- R11: After reset the buffer is empty: `st_ready` = 1, `drn_valid` = 0 and no load hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Executed store present |
| st_tag | input | TAG_W | Program-order tag of the store |
| st_addr | input | ADDR_W | Store address |
| st_data | input | DATA_W | Store data |
| st_ready | output | 1 | A free entry exists |
| cm_valid | input | 1 | Commit request |
| cm_tag | input | TAG_W | Tag of the committing store |
| ab_valid | input | 1 | Abort request |
| ab_tag | input | TAG_W | Tag of the aborted store |
| ld_valid | input | 1 | Load lookup request |
| ld_tag | input | TAG_W | Program-order tag of the load |
| ld_addr | input | ADDR_W | Load address |
| ld_hit | output | 1 | Buffered data supplied |
| ld_data | output | DATA_W | Forwarded store data |
| drn_valid | output | 1 | Committed entry offered to the cache |
| drn_addr | output | ADDR_W | Address of the offered entry |
| drn_data | output | DATA_W | Data of the offered entry |
| drn_ready | input | 1 | Cache accepts the write |

## Verification
The bench drives loads against addresses where the cache already holds a different value. A buffer that let the cache win, or that wrote memory before commit, therefore returns the wrong word. Several stores to one address are queried with load tags placed between them. A selector that took the oldest match or ignored age would return a neighbouring store's data. Tags straddling the wrap point catch a plain unsigned compare, which would miss forwarding and would drain the wrapped store first. A full buffer is pushed once more, and an aborted entry is checked to vanish from both loads and drains.

// File: rtl/spec_store_buf.sv
module spec_store_buf #(
  parameter int DEPTH  = 4,
  parameter int TAG_W  = 5,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_valid,
  input  logic [TAG_W-1:0]  st_tag,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [DATA_W-1:0] st_data,
  output logic              st_ready,
  input  logic              cm_valid,
  input  logic [TAG_W-1:0]  cm_tag,
  input  logic              ab_valid,
  input  logic [TAG_W-1:0]  ab_tag,
  input  logic              ld_valid,
  input  logic [TAG_W-1:0]  ld_tag,
  input  logic [ADDR_W-1:0] ld_addr,
  output logic              ld_hit,
  output logic [DATA_W-1:0] ld_data,
  output logic              drn_valid,
  output logic [ADDR_W-1:0] drn_addr,
  output logic [DATA_W-1:0] drn_data,
  input  logic              drn_ready
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DEPTH-1:0]  vld_q, spec_q;
  logic [TAG_W-1:0]  tag_q  [DEPTH];
  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];

  logic [IDX_W-1:0] free_idx, ld_sel, drn_sel;
  logic             has_free, ld_match;
  logic [CNT_W-1:0] occ;

  function automatic logic is_older(input logic [TAG_W-1:0] a, input logic [TAG_W-1:0] b);
    logic [TAG_W-1:0] d;
    d = a - b;
    return d[TAG_W-1];
  endfunction

  always_comb begin
    has_free = 1'b0;
    free_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (!vld_q[i]) begin
        has_free = 1'b1;
        free_idx = IDX_W'(i);
      end
  end

  always_comb begin
    ld_match = 1'b0;
    ld_sel   = '0;
    for (int i = 0; i < DEPTH; i++)
      if (vld_q[i] && addr_q[i] == ld_addr && is_older(tag_q[i], ld_tag) &&
          (!ld_match || is_older(tag_q[ld_sel], tag_q[i]))) begin
        ld_match = 1'b1;
        ld_sel   = IDX_W'(i);
      end
  end

  always_comb begin
    drn_valid = 1'b0;
    drn_sel   = '0;
    for (int i = 0; i < DEPTH; i++)
      if (vld_q[i] && !spec_q[i] &&
          (!drn_valid || is_older(tag_q[i], tag_q[drn_sel]))) begin
        drn_valid = 1'b1;
        drn_sel   = IDX_W'(i);
      end
  end

  always_comb begin
    occ = '0;
    for (int i = 0; i < DEPTH; i++) occ = occ + CNT_W'(vld_q[i]);
  end

  assign st_ready = has_free;
  assign ld_hit   = ld_valid && ld_match;
  assign ld_data  = data_q[ld_sel];
  assign drn_addr = addr_q[drn_sel];
  assign drn_data = data_q[drn_sel];

  wire st_fire  = st_valid && has_free;
  wire drn_fire = drn_valid && drn_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q  <= '0;
      spec_q <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (cm_valid && vld_q[i] && spec_q[i] && tag_q[i] == cm_tag) spec_q[i] <= 1'b0;
        if (ab_valid && vld_q[i] && spec_q[i] && tag_q[i] == ab_tag) vld_q[i] <= 1'b0;
        if (drn_fire && drn_sel == IDX_W'(i)) vld_q[i] <= 1'b0;
        if (st_fire && free_idx == IDX_W'(i)) begin
          vld_q[i]  <= 1'b1;
          spec_q[i] <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++)
      if (st_fire && free_idx == IDX_W'(i)) begin
        tag_q[i]  <= st_tag;
        addr_q[i] <= st_addr;
        data_q[i] <= st_data;
      end
  end

  p_grow_one_r1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (int'(occ) <= int'($past(occ)) + 1));

  p_drain_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    drn_valid && !drn_ready |=> drn_valid);

  p_drain_after_commit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drn_valid) |-> $past(cm_valid));

  p_full_refuse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    int'(occ) == DEPTH |-> !st_ready);

  p_hit_needs_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ld_hit |-> occ != '0);
endmodule

// File: tb/spec_store_buf_tb.sv
`timescale 1ns/1ps
module spec_store_buf_tb;
  localparam int TAG_W = 5, ADDR_W = 8, DATA_W = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic st_valid = 0, cm_valid = 0, ab_valid = 0, ld_valid = 0, drn_ready = 0;
  logic [TAG_W-1:0] st_tag = 0, cm_tag = 0, ab_tag = 0, ld_tag = 0;
  logic [ADDR_W-1:0] st_addr = 0, ld_addr = 0;
  logic [DATA_W-1:0] st_data = 0;
  logic st_ready, ld_hit, drn_valid;
  logic [DATA_W-1:0] ld_data, drn_data;
  logic [ADDR_W-1:0] drn_addr;

  logic [DATA_W-1:0] mem [256];
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  spec_store_buf u_dut (.*);

  always @(posedge clk) if (drn_valid && drn_ready) mem[drn_addr] <= drn_data;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic store(input logic [TAG_W-1:0] t, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    st_valid = 1; st_tag = t; st_addr = a; st_data = d;
    @(negedge clk); st_valid = 0;
  endtask

  task automatic commit(input logic [TAG_W-1:0] t);
    cm_valid = 1; cm_tag = t; @(negedge clk); cm_valid = 0;
  endtask

  task automatic abort_st(input logic [TAG_W-1:0] t);
    ab_valid = 1; ab_tag = t; @(negedge clk); ab_valid = 0;
  endtask

  task automatic load(input string req, input logic [TAG_W-1:0] t, input logic [ADDR_W-1:0] a,
                      input logic [DATA_W-1:0] exp);
    logic [DATA_W-1:0] got;
    ld_valid = 1; ld_tag = t; ld_addr = a; #1;
    got = ld_hit ? ld_data : mem[a];
    chk(req, got, exp);
    ld_valid = 0;
  endtask

  task automatic take(input string req, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    chk({req, " valid"}, drn_valid, 1);
    chk({req, " addr"}, drn_addr, a);
    chk({req, " data"}, drn_data, d);
    drn_ready = 1; @(negedge clk); drn_ready = 0;
  endtask

  task automatic t_reset;
    chk("R11 st_ready", st_ready, 1);
    chk("R11 drn_valid", drn_valid, 0);
    ld_valid = 1; ld_addr = 8'h10; ld_tag = 5; #1;
    chk("R11 ld_hit", ld_hit, 0);
    ld_valid = 0;
  endtask

  task automatic t_basic;
    store(1, 8'h20, 16'hAAAA);
    chk("R1 no drain while speculative", drn_valid, 0);
    load("R4 buffer over cache", 2, 8'h20, 16'hAAAA);
    load("R6 load same tag ignores store", 1, 8'h20, 16'hC020);
    repeat (2) @(negedge clk);
    chk("R1 cache untouched", mem[8'h20], 16'hC020);
    commit(1);
    drn_ready = 0; @(negedge clk);
    chk("R7 offer held without ready", drn_valid, 1);
    take("R2 drain after commit", 8'h20, 16'hAAAA);
    chk("R7 freed after accept", drn_valid, 0);
    chk("R2 cache written", mem[8'h20], 16'hAAAA);
    load("R9 miss after drain", 3, 8'h21, 16'hC021);
  endtask

  task automatic t_abort;
    store(4, 8'h30, 16'h1111);
    abort_st(4);
    load("R3 aborted store invisible", 6, 8'h30, 16'hC030);
    chk("R3 aborted store not offered", drn_valid, 0);
    commit(4);
    chk("R3 commit after abort no drain", drn_valid, 0);
  endtask

  task automatic t_youngest;
    store(8, 8'h40, 16'h0008);
    store(10, 8'h40, 16'h000A);
    store(12, 8'h40, 16'h000C);
    store(11, 8'h41, 16'h000B);
    load("R5 youngest older", 11, 8'h40, 16'h000A);
    load("R5 all older", 13, 8'h40, 16'h000C);
    load("R6 younger ignored", 9, 8'h40, 16'h0008);
    load("R9 none older", 8, 8'h40, 16'hC040);
    chk("R8 full", st_ready, 0);
    store(14, 8'h50, 16'hDEAD);
    load("R8 refused store absent", 15, 8'h50, 16'hC050);
    commit(8); commit(10); commit(11); commit(12);
    take("R7 oldest first a", 8'h40, 16'h0008);
    take("R7 oldest first b", 8'h40, 16'h000A);
    take("R7 oldest first c", 8'h41, 16'h000B);
    take("R7 oldest first d", 8'h40, 16'h000C);
    chk("R8 only four drained", drn_valid, 0);
    chk("R3 slots reusable", st_ready, 1);
  endtask

  task automatic t_wrap;
    store(30, 8'h60, 16'h001E);
    store(31, 8'h60, 16'h001F);
    store(0, 8'h60, 16'h0020);
    store(1, 8'h61, 16'h0021);
    load("R10 wrapped load sees tag 31", 0, 8'h60, 16'h001F);
    load("R10 wrapped load sees tag 0", 2, 8'h60, 16'h0020);
    commit(30); commit(31); commit(0); commit(1);
    take("R10 drain 30", 8'h60, 16'h001E);
    take("R10 drain 31", 8'h60, 16'h001F);
    take("R10 drain 0", 8'h60, 16'h0020);
    take("R10 drain 1", 8'h61, 16'h0021);
    chk("R10 cache final", mem[8'h60], 16'h0020);
  endtask

  initial begin
    for (int a = 0; a < 256; a++) mem[a] = 16'hC000 | 16'(a);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_abort();
    t_youngest();
    t_wrap();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #100000;
    n_chk++; n_bad++;
    $display("FAIL watchdog got=hang expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule